// File: doc/BRIEF.md
# Packed Lane Wraparound Subtractor

This block takes two 256-bit operand vectors, splits them into equal integer lanes of 8, 16, 32 or 64 bits, and subtracts each lane of the second operand from the matching lane of the first. Every lane result keeps only its low bits, and any borrow out of a lane is dropped. Two's-complement and unsigned operands give the same bit pattern, so the block has no signedness control and no status outputs.

A write-mode input sets how the upper half of the result is formed. The merge mode computes only the lower 128 bits and passes the upper half of a supplied prior destination value through unchanged. The zero-upper mode computes the lower 128 bits and clears the upper half. The full mode computes all 256 bits. The result and a valid flag are registered one clock after a valid strobe. A host pipeline presents one operation per valid cycle and reads the registered result on the following cycle.

Top module: `pkd_wrap_sub`

## Requirements
- R1: For each lane, the result lane equals first-operand lane minus second-operand lane modulo 2^w, where w is the lane width.
- R2: No borrow crosses a lane boundary: each lane's result depends only on that lane's operand bits.
- R3: `lane_sel` encodes the lane width: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 = 32 bits, 2'b11 = 64 bits. Lane k of width w occupies bits w*k+w-1 down to w*k.
- R4: With `mode_sel` = 2'b00 (merge), bits 127:0 hold the lane differences and bits 255:128 equal `dst_old[255:128]` as sampled with the strobe.
- R5: With `mode_sel` = 2'b01 (zero-upper), bits 127:0 hold the lane differences and bits 255:128 are zero.
- R6: With `mode_sel` = 2'b10 (full), all lanes across bits 255:0 hold differences; the reserved code 2'b11 gives the same result as 2'b10.
- R7: `res_valid` is high in exactly the cycle after a cycle with `in_valid` high, and the result of that operation appears in the same cycle.
- R8: While `in_valid` is low, `res_q` keeps its last value.
- R9: A synchronous active-high `rst` clears `res_q` to zero and `res_valid` to low on the next clock edge.
- R10: Boundary operands wrap: 0 minus the all-ones lane value gives 1, and the most negative signed lane value minus 1 gives the largest positive signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 256 | First operand (minuend) vector |
| src_b | input | 256 | Second operand (subtrahend) vector |
| dst_old | input | 256 | Prior destination value, used for the upper half in merge mode |
| lane_sel | input | 2 | Lane width select |
| mode_sel | input | 2 | Upper-half write mode |
| res_q | output | 256 | Registered result |
| res_valid | output | 1 | Result valid flag |

## Verification
The assertions assume that `lane_sel`, `mode_sel` and all three vectors are stable and known whenever `in_valid` is sampled high, and that `rst` is applied from the first edge, so the properties only compare values captured in a strobe cycle with the register contents one edge later. The stimulus changes inputs only at the falling clock edge, holds every field steady across the rising edge that captures it, and drives known values during reset so no unknown vector reaches the comparison. Random operands are mixed with lane-boundary patterns and with idle gaps, which exercise the hold and valid-drop properties.

// File: rtl/pkd_wrap_sub_pkg.sv
package pkd_wrap_sub_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_B16 = 2'b01,
        LANE_B32 = 2'b10,
        LANE_B64 = 2'b11
    } lane_sz_e;

    typedef enum logic [1:0] {
        WM_MERGE = 2'b00,
        WM_ZUP   = 2'b01,
        WM_FULL  = 2'b10,
        WM_RSVD  = 2'b11
    } wmode_e;

endpackage

// File: rtl/lane_break_gen.sv
// Marks the bytes at which a new lane starts for the selected lane width.
module lane_break_gen #(
    parameter int NSEG = 32,
    parameter int SELW = 2
) (
    input  logic [SELW-1:0] lane_log2,
    output logic [NSEG-1:0] seg_start
);
    localparam int MW = (1 << SELW) - 1;

    logic [MW-1:0] lmask;

    always_comb begin
        lmask = '0;
        for (int i = 0; i < MW; i++) begin
            if (i < int'(lane_log2)) lmask[i] = 1'b1;
        end
    end

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam logic [MW-1:0] KIDX = MW'(k);
        assign seg_start[k] = ((KIDX & lmask) == '0);
    end
endmodule

// File: rtl/borrow_split_sub.sv
// One wide subtractor (a + ~b + 1) whose carry chain restarts at every lane start.
module borrow_split_sub #(
    parameter int W   = 256,
    parameter int SEG = 8
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [W/SEG-1:0] seg_start,
    output logic [W-1:0]     diff
);
    localparam int NSEG = W / SEG;

    always_comb begin
        logic         c;
        logic         cin;
        logic [SEG:0] s;
        c    = 1'b1;
        diff = '0;
        for (int k = 0; k < NSEG; k++) begin
            cin = (seg_start[k] || k == 0) ? 1'b1 : c;
            s   = {1'b0, a[k*SEG +: SEG]} + {1'b0, ~b[k*SEG +: SEG]}
                + {{SEG{1'b0}}, cin};
            diff[k*SEG +: SEG] = s[SEG-1:0];
            c = s[SEG];
        end
    end
endmodule

// File: rtl/upper_merge.sv
// Forms the upper half of the destination according to the write mode.
module upper_merge
    import pkd_wrap_sub_pkg::*;
#(
    parameter int W = 256
) (
    input  logic [W-1:0] diff,
    input  logic [W-1:0] prior,
    input  wmode_e       mode,
    output logic [W-1:0] dout
);
    localparam int HALF = W / 2;

    always_comb begin
        dout[HALF-1:0] = diff[HALF-1:0];
        case (mode)
            WM_MERGE: dout[W-1:HALF] = prior[W-1:HALF];
            WM_ZUP:   dout[W-1:HALF] = '0;
            default:  dout[W-1:HALF] = diff[W-1:HALF];
        endcase
    end
endmodule

// File: rtl/pkd_wrap_sub.sv
module pkd_wrap_sub
    import pkd_wrap_sub_pkg::*;
#(
    parameter int W   = 256,
    parameter int SEG = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic [W-1:0] dst_old,
    input  logic [1:0]   lane_sel,
    input  logic [1:0]   mode_sel,
    output logic [W-1:0] res_q,
    output logic         res_valid
);
    localparam int NSEG = W / SEG;
    localparam int HALF = W / 2;

    typedef struct packed {
        logic [W-1:0] res;
        logic         vld;
    } state_t;

    state_t          state_d, state_q;
    logic [NSEG-1:0] seg_start;
    logic [W-1:0]    diff;
    logic [W-1:0]    merged;
    lane_sz_e        lane_e;
    wmode_e          mode_e;

    assign lane_e = lane_sz_e'(lane_sel);
    assign mode_e = wmode_e'(mode_sel);

    lane_break_gen #(.NSEG(NSEG), .SELW(2)) u_brk (
        .lane_log2 (lane_e),
        .seg_start (seg_start)
    );

    borrow_split_sub #(.W(W), .SEG(SEG)) u_sub (
        .a         (src_a),
        .b         (src_b),
        .seg_start (seg_start),
        .diff      (diff)
    );

    upper_merge #(.W(W)) u_mrg (
        .diff  (diff),
        .prior (dst_old),
        .mode  (mode_e),
        .dout  (merged)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) state_d.res = merged;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign res_q     = state_q.res;
    assign res_valid = state_q.vld;

    // R7
    valid_track_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res_q));

    // R4
    merge_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == 2'b00) |=>
            res_q[W-1:HALF] == $past(dst_old[W-1:HALF]));

    // R5
    zero_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_sel == 2'b01) |=> res_q[W-1:HALF] == '0);

    // R1
    low_byte_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_q[7:0] == 8'($past(src_a[7:0]) - $past(src_b[7:0])));
endmodule

// File: tb/sim_pkd_wrap_sub.sv
`timescale 1ns/1ps
module sim_pkd_wrap_sub;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [W-1:0] src_a, src_b, dst_old;
    logic [1:0]   lane_sel, mode_sel;
    logic [W-1:0] res_q;
    logic         res_valid;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_res;
    logic         exp_vld;

    always #2 clk = ~clk;

    pkd_wrap_sub u0 (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .src_a (src_a), .src_b (src_b), .dst_old (dst_old),
        .lane_sel (lane_sel), .mode_sel (mode_sel),
        .res_q (res_q), .res_valid (res_valid)
    );

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] d, input int ls, input int md);
        int w = 8 << ls;
        int span = (md == 0 || md == 1) ? 128 : 256;
        logic [W-1:0] m = (W'(1) << w) - W'(1);
        logic [W-1:0] r = '0;
        for (int i = 0; i < W / w; i++) begin
            if (i * w < span) begin
                logic [W-1:0] x = (((a >> (i * w)) & m) - ((b >> (i * w)) & m)) & m;
                r = r | (x << (i * w));
            end
        end
        if (md == 0) r[W-1:128] = d[W-1:128];
        return r;
    endfunction

    function automatic logic [W-1:0] rnd();
        logic [W-1:0] v;
        for (int i = 0; i < W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (res_q !== exp_res) begin
            fails++;
            $display("FAIL %s res actual=%h expected=%h", tag, res_q, exp_res);
        end
        checks++;
        if (res_valid !== exp_vld) begin
            fails++;
            $display("FAIL %s valid actual=%b expected=%b", tag, res_valid, exp_vld);
        end
    endtask

    // drive at negedge, compare 1 ns after the capturing posedge
    task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] d, input int ls, input int md, input string tag);
        logic [W-1:0] nxt;
        @(negedge clk);
        in_valid = v; src_a = a; src_b = b; dst_old = d;
        lane_sel = 2'(ls); mode_sel = 2'(md);
        nxt = v ? model(a, b, d, ls, md) : exp_res;
        @(posedge clk); #1;
        exp_res = nxt; exp_vld = v;
        compare(tag);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] ones;
        ones = '1;
        rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0; dst_old = '0;
        lane_sel = 2'b00; mode_sel = 2'b10;
        repeat (3) @(posedge clk);
        #1;
        exp_res = '0; exp_vld = 1'b0;
        compare("R9 reset");
        @(negedge clk); rst = 1'b0;

        // R1 R3 R6: random operands, every lane size and mode
        for (int ls = 0; ls < 4; ls++)
            for (int md = 0; md < 4; md++)
                for (int n = 0; n < 4; n++)
                    step(1'b1, rnd(), rnd(), rnd(), ls, md, "R1 R3 R6 random");

        // R2: borrows must stop at lane boundaries
        for (int ls = 0; ls < 4; ls++) begin
            step(1'b1, '0, {32{8'h01}}, '0, ls, 2, "R2 borrow isolation");
            step(1'b1, {32{8'h00}}, {16{16'h0100}}, '0, ls, 2, "R2 borrow isolation");
        end

        // R10: 0 - max and min - 1 per lane size
        for (int ls = 0; ls < 4; ls++) begin
            logic [W-1:0] minv;
            int w = 8 << ls;
            minv = '0;
            for (int i = 0; i < W / w; i++) minv[i*w + w - 1] = 1'b1;
            step(1'b1, '0, ones, '0, ls, 2, "R10 zero minus max");
            step(1'b1, minv, {(W/8){8'h00}} | W'(0) | repeat_one(ls), '0, ls, 2, "R10 min minus one");
        end

        // R4 R5 R6: upper-half modes with known prior value
        step(1'b1, ones, W'(0), {W{1'b1}} ^ {128'h0, 128'h0}, 0, 0, "R4 merge upper");
        step(1'b1, rnd(), rnd(), rnd(), 1, 1, "R5 zero upper");
        step(1'b1, rnd(), rnd(), rnd(), 2, 3, "R6 reserved as full");

        // R7 R8: idle gaps hold the result and drop valid
        step(1'b1, rnd(), rnd(), rnd(), 3, 2, "R7 strobe");
        step(1'b0, rnd(), rnd(), rnd(), 0, 1, "R8 idle hold");
        step(1'b0, rnd(), rnd(), rnd(), 1, 0, "R8 idle hold");
        step(1'b1, rnd(), rnd(), rnd(), 0, 2, "R7 strobe after gap");

        // R9: reset mid-stream
        @(negedge clk); rst = 1'b1; in_valid = 1'b1;
        @(posedge clk); #1;
        exp_res = '0; exp_vld = 1'b0;
        compare("R9 mid reset");
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        step(1'b1, rnd(), rnd(), rnd(), 2, 2, "R1 after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [W-1:0] repeat_one(input int ls);
        logic [W-1:0] v = '0;
        int w = 8 << ls;
        for (int i = 0; i < W / w; i++) v[i*w] = 1'b1;
        return v;
    endfunction
endmodule